// File: doc/BRIEF.md
# Third-Order Frequency-Offset History Filter

This block smooths a stream of signed frequency-offset samples, each the measured offset between the synthesized output clock and the master clock. It runs them through a third-order low-pass filter built from three identical leaky integrators in a chain. The filtered value is always available on `hist_o`, so holdover logic and diagnostics can read it at any time.

A bandwidth code sets the corner. Each code step halves the corner, and code 0 is the widest. A short-history use instantiates the block with a 2-bit code, which gives four corners one octave apart. A long-history use takes a wider code that spans about fourteen octaves.

A flush pulse clears all filter state. The narrowest codes would otherwise take very long to settle, so they use a temporary fast-settle window after reset, after a flush, or after a code change. During that window the shift is clamped to a smaller value for a fixed number of accepted samples.

Top module: `hist_lpf3`

## Requirements
- R1: After reset, all three stage states are zero, `hist_o` is 0, and a fast-settle window of FAST_TICKS accepted samples is armed.
- R2: On each clock edge with `valid_i` high and `flush_i` low, every stage updates as y <= y + ((x - y) >>> k), all three on the same edge. Stage 1 takes `sample_i` scaled up by FRAC_W fractional bits. Stages 2 and 3 take the previous stage's value as it was before that edge. The shift is arithmetic, so it rounds toward minus infinity.
- R3: The programmed shift is k = K_BASE + `bw_code_i`, with the code read as unsigned. Each code increment therefore halves the corner.
- R4: On an edge with `valid_i` low and `flush_i` low, the filter state is unchanged.
- R5: On an edge with `flush_i` high, all stage states become zero, a sample offered on that edge is ignored, and the fast-settle window restarts.
- R6: When `bw_code_i` >= NARROW_CODE and the window count is nonzero, the shift used is min(K_BASE + code, FAST_K). Each accepted sample decrements the count. Once the count reaches zero, the programmed shift applies.
- R7: An edge on which `bw_code_i` differs from its value on the previous edge reloads the window count to FAST_TICKS. A sample on that same edge uses the shift given by the count before the reload.
- R8: `hist_o` equals stage 3's state shifted arithmetically right by FAST_W... see R2 scaling: it is stage 3's state >>> FRAC_W, floored, and it is valid from the clock after each update.
- R9: No stage state ever leaves the range of the scaled input word, including when full-scale samples of both signs alternate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | SAMPLE_W | Signed frequency-offset sample |
| bw_code_i | input | CODE_W | Bandwidth code, 0 is widest |
| flush_i | input | 1 | Clears filter state |
| hist_o | output | SAMPLE_W | Filtered offset, signed |

## Verification
The hardest condition to reach is the exact sample on which the fast-settle window expires, particularly when a code change lands in the same cycle as an accepted sample. The stimulus gets there in two ways. It restarts the window with a flush and with code changes. It then feeds a counted run of samples with idle cycles interleaved, because idle cycles must not consume the window. A behavioural model tracks the remaining count, so the bench can compare the switch from the clamped shift to the programmed shift on the precise sample where it happens.

// File: rtl/hist_lpf_pkg.sv
package hist_lpf_pkg;
  localparam int unsigned NUM_STAGES = 3;

  function automatic int unsigned k_max(input int unsigned k_base, input int unsigned code_w);
    return k_base + (2 ** code_w) - 1;
  endfunction
endpackage

// File: rtl/hist_kctl.sv
module hist_kctl #(
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned K_BASE      = 3,
  parameter int unsigned NARROW_CODE = 10,
  parameter int unsigned FAST_K      = 8,
  parameter int unsigned FAST_TICKS  = 64,
  parameter int unsigned K_W         = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              flush_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [K_W-1:0]    k_o
);
  localparam int unsigned CNT_W = $clog2(FAST_TICKS + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(FAST_TICKS);
  localparam logic [K_W-1:0] K_BASE_V = K_W'(K_BASE);
  localparam logic [K_W-1:0] FAST_K_V = K_W'(FAST_K);
  localparam logic [K_W-1:0] K_TOP_V  = K_W'(hist_lpf_pkg::k_max(K_BASE, CODE_W));

  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_prev_q;
  logic [K_W-1:0]    k_prog, k_fast;
  logic              narrow, fast_sel, restart;

  assign k_prog   = K_BASE_V + K_W'(code_i);
  assign k_fast   = (k_prog < FAST_K_V) ? k_prog : FAST_K_V;
  assign narrow   = int'(code_i) >= int'(NARROW_CODE);
  assign fast_sel = narrow && (cnt_q != '0);
  assign k_o      = fast_sel ? k_fast : k_prog;
  assign restart  = flush_i || (code_i != code_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= RELOAD;
      code_prev_q <= '0;
    end else begin
      code_prev_q <= code_i;
      if (restart) cnt_q <= RELOAD;
      else if (valid_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R6
  win_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !restart && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R7
  win_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> cnt_q == RELOAD);
  // R4
  win_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !restart) |=> $stable(cnt_q));
  // R3
  k_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_o <= K_TOP_V && (k_o >= K_BASE_V || k_o == FAST_K_V));
endmodule

// File: rtl/hist_stage.sv
module hist_stage #(
  parameter int unsigned ACC_W = 42,
  parameter int unsigned K_W   = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    flush_i,
  input  logic [K_W-1:0]          k_i,
  input  logic signed [ACC_W-1:0] x_i,
  output logic signed [ACC_W-1:0] y_o
);
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W:0]   diff, step;
  logic                    unused_step_msb;

  assign diff  = $signed({x_i[ACC_W-1], x_i}) - $signed({acc_q[ACC_W-1], acc_q});
  assign step  = diff >>> k_i;
  assign acc_d = acc_q + step[ACC_W-1:0];
  assign unused_step_msb = step[ACC_W];
  assign y_o   = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (flush_i)  acc_q <= '0;
    else if (valid_i)  acc_q <= acc_d;
  end

  // R5
  flush_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> acc_q == '0);
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !flush_i) |=> $stable(acc_q));
  // R9
  toward_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !flush_i) |=>
      (($past(x_i) >= $past(acc_q)) ?
        (acc_q >= $past(acc_q) && acc_q <= $past(x_i)) :
        (acc_q <  $past(acc_q) && acc_q >= $past(x_i))));
endmodule

// File: rtl/hist_lpf3.sv
module hist_lpf3 #(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned K_BASE      = 3,
  parameter int unsigned NARROW_CODE = 10,
  parameter int unsigned FAST_K      = 8,
  parameter int unsigned FAST_TICKS  = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [CODE_W-1:0]          bw_code_i,
  input  logic                       flush_i,
  output logic signed [SAMPLE_W-1:0] hist_o
);
  import hist_lpf_pkg::*;

  localparam int unsigned K_TOP  = k_max(K_BASE, CODE_W);
  localparam int unsigned K_W    = $clog2(K_TOP + 1);
  localparam int unsigned FRAC_W = K_TOP;
  localparam int unsigned ACC_W  = SAMPLE_W + FRAC_W;

  logic [K_W-1:0]          k_w;
  logic signed [ACC_W-1:0] chain_w [NUM_STAGES+1];
  logic                    unused_frac;

  hist_kctl #(
    .CODE_W(CODE_W), .K_BASE(K_BASE), .NARROW_CODE(NARROW_CODE),
    .FAST_K(FAST_K), .FAST_TICKS(FAST_TICKS), .K_W(K_W)
  ) kctl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .flush_i(flush_i),
    .code_i(bw_code_i), .k_o(k_w)
  );

  assign chain_w[0] = {sample_i, {FRAC_W{1'b0}}};

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    hist_stage #(.ACC_W(ACC_W), .K_W(K_W)) stage_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .flush_i(flush_i),
      .k_i(k_w), .x_i(chain_w[g]), .y_o(chain_w[g+1])
    );
  end

  assign hist_o      = chain_w[NUM_STAGES][ACC_W-1:FRAC_W];
  assign unused_frac = ^chain_w[NUM_STAGES][FRAC_W-1:0];

  // R5
  out_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> hist_o == '0);
  // R8
  out_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !flush_i) |=> $stable(hist_o));
endmodule

// File: tb/hist_lpf3_tb_top.sv
module hist_lpf3_tb_top;
  localparam int SW = 24, CW = 4, KB = 3, NC = 10, FK = 8, FT = 64;
  localparam int F = KB + (2 ** CW) - 1;

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, flush_i = 1'b0;
  logic signed [SW-1:0] sample_i = '0;
  logic [CW-1:0] bw_code_i = '0;
  logic signed [SW-1:0] hist_o;

  int checks = 0, fails = 0;
  longint my [3];
  int mcnt = FT, mprev = 0;

  always #10 clk = ~clk;

  hist_lpf3 #(.SAMPLE_W(SW), .CODE_W(CW), .K_BASE(KB), .NARROW_CODE(NC),
              .FAST_K(FK), .FAST_TICKS(FT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sample_i(sample_i),
    .bw_code_i(bw_code_i), .flush_i(flush_i), .hist_o(hist_o));

  function automatic longint model_out();
    return my[2] >>> F;
  endfunction

  task automatic check(input longint act, input longint exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: hist_o=%0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model(input logic v, input longint s, input int c, input logic f);
    int ke, kp;
    longint n0, n1, n2;
    kp = KB + c;
    ke = (mcnt != 0 && c >= NC) ? ((kp < FK) ? kp : FK) : kp;
    if (f) begin
      my[0] = 0; my[1] = 0; my[2] = 0;
    end else if (v) begin
      n0 = my[0] + (((s <<< F) - my[0]) >>> ke);
      n1 = my[1] + ((my[0] - my[1]) >>> ke);
      n2 = my[2] + ((my[1] - my[2]) >>> ke);
      my[0] = n0; my[1] = n1; my[2] = n2;
    end
    if (f || c != mprev) mcnt = FT;
    else if (v && mcnt != 0) mcnt--;
    mprev = c;
  endtask

  task automatic step(input logic v, input longint s, input int c, input logic f, input string req);
    valid_i = v; sample_i = SW'(s); bw_code_i = CW'(c); flush_i = f;
    model(v, s, c, f);
    @(negedge clk);
    check(longint'(hist_o), model_out(), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    my[0] = 0; my[1] = 0; my[2] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    check(longint'(hist_o), 0, "R1");
    // R2 R3 step response at widest code, idle gaps R4
    for (int i = 0; i < 40; i++) step((i % 3) != 2, 1000, 0, 0, (i % 3 == 2) ? "R4" : "R2");
    // R3 next code, negative step
    for (int i = 0; i < 30; i++) step(1, -500000, 1, 0, "R3");
    // R9 full-scale alternation
    for (int i = 0; i < 40; i++) step(1, (i % 2) ? -8388608 : 8388607, 0, 0, "R9");
    for (int i = 0; i < 20; i++) step(1, 8388607, 2, 0, "R9");
    // R5 flush with a sample offered
    step(1, 4000000, 2, 1, "R5");
    check(longint'(hist_o), 0, "R5");
    for (int i = 0; i < 10; i++) step(1, 250000, 2, 0, "R8");
    // R6 narrow code: code change restarts window; idle cycles do not consume it
    for (int i = 0; i < 90; i++) step((i % 4) != 3, 300000, 12, 0, "R6");
    for (int i = 0; i < 60; i++) step(1, 300000, 12, 0, "R6");
    // R7 code change on an accepted sample, then window expiry
    step(1, -200000, 11, 0, "R7");
    for (int i = 0; i < 70; i++) step(1, -200000, 11, 0, "R7");
    step(1, -200000, 13, 0, "R7");
    for (int i = 0; i < 66; i++) step(1, 100000, 13, 0, "R7");
    // R5 flush restarts window at narrow code
    step(0, 0, 13, 1, "R5");
    for (int i = 0; i < 70; i++) step(1, 700000, 13, 0, "R6");
    for (int i = 0; i < 5; i++) step(0, 0, 13, 0, "R4");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule